// File: doc/BRIEF.md
# PLL Configuration Register Bank

This block holds the configuration words for four phase-locked loops behind a simple 32-bit memory-mapped register bus. Software writes divider and mode bits into each word and reads them back. Two bits of each word are status rather than configuration: a lock indicator and a sticky loss-of-lock flag. Both are derived from the power-down request bit of the same written word, so a stored word is not always an exact copy of the data written.

There is no analog loop behind the bank. A loop that is not powered down is taken to be locked. Powering a loop down drops its lock indicator and raises the loss-of-lock flag. That flag then stays set until software clears it by writing a one to it while the loop is powered. Reads are registered: the read data appears on the clock edge after the read strobe and holds until the next read.

Top module: `pll_cfg_bank`

## Requirements
- R1: After reset the four words read 0x80222101, 0x80202101, 0x80C02105 and 0x81228606 (slot 0 to slot 3). Each is its base value with the lock indicator at bit 31 set.
- R2: A write with the power-down bit (bit 12) set stores the word with lock (bit 31) cleared and loss-of-lock (bit 30) set, whatever the written values of those two bits.
- R3: A write with bit 12 clear stores the word with bit 31 set.
- R4: A write with bit 12 clear and bit 30 set clears the stored loss-of-lock flag.
- R5: A write with bit 12 clear and bit 30 clear leaves the stored loss-of-lock flag at its previous value.
- R6: Every bit other than 31 and 30 is stored and read back exactly as written. This includes bit 12.
- R7: Slot k sits at byte offset 4*k. A write changes only the addressed slot.
- R8: An access whose byte enables are not all four set, whose address is not 4-byte aligned (addr[1:0] nonzero), or whose offset is 0x10 or above, is ignored when it is a write. Such an access returns zero when it is a read.
- R9: Read data is updated on the clock edge after a cycle with the read strobe high and holds otherwise. A read in the same cycle as a write to the same slot returns the content from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous cold reset |
| wr_en_i | input | 1 | Single-cycle write strobe |
| rd_en_i | input | 1 | Single-cycle read strobe |
| addr_i | input | ADDR_W (6) | Byte address |
| be_i | input | 4 | Byte enables, little-endian lanes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |

## Verification
The hardest state to reach is a loss-of-lock flag that is set while the loop is powered again. To get there, a power-down write must be followed by a powered write that leaves bit 30 at zero. The read that follows then shows whether the flag was kept sticky or dropped. The stimulus builds this sequence directly and then clears the flag. The random phase biases bit 12 and bit 30 so that such sequences recur on every slot. It mixes in misaligned, partial-enable and out-of-range accesses whose effect, or lack of it, shows up on the next read.

// File: rtl/pllb_pkg.sv
package pllb_pkg;

    localparam int WORD_W   = 32;
    localparam int BE_W     = WORD_W / 8;
    localparam int LOCK_BIT = 31;
    localparam int LOSS_BIT = 30;
    localparam int PDN_BIT  = 12;

    localparam logic [WORD_W-1:0] LOCK_M = WORD_W'(1) << LOCK_BIT;
    localparam logic [WORD_W-1:0] LOSS_M = WORD_W'(1) << LOSS_BIT;
    localparam logic [WORD_W-1:0] CFG_M  = ~(LOCK_M | LOSS_M);

    // Base cold-reset configuration for slot idx; lock bit added on top.
    function automatic logic [WORD_W-1:0] cold_word(input int idx);
        logic [WORD_W-1:0] base;
        case (idx)
            0:       base = 32'h0022_2101;
            1:       base = 32'h0020_2101;
            2:       base = 32'h00C0_2105;
            3:       base = 32'h0122_8606;
            default: base = '0;
        endcase
        return base | LOCK_M;
    endfunction

    // Word stored after a write of wr over the current content cur.
    function automatic logic [WORD_W-1:0] merge_write(
        input logic [WORD_W-1:0] cur,
        input logic [WORD_W-1:0] wr
    );
        logic [WORD_W-1:0] res;
        res = wr & CFG_M;
        if (wr[PDN_BIT]) begin
            res = res | LOSS_M;
        end else begin
            res = res | LOCK_M;
            if (!wr[LOSS_BIT]) begin
                res = res | (cur & LOSS_M);
            end
        end
        return res;
    endfunction

    typedef struct packed {
        logic [WORD_W-1:0] word;
    } slot_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
    } rd_state_t;

endpackage

// File: rtl/pllb_decode.sv
module pllb_decode
    import pllb_pkg::*;
#(
    parameter int N_REG  = 4,
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BE_W-1:0]   be_i,
    output logic              ok_o,
    output logic [N_REG-1:0]  sel_o
);
    localparam int WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] widx;
    logic              aligned;
    logic              full_be;
    logic              in_range;

    always_comb begin
        widx     = addr_i[ADDR_W-1:2];
        aligned  = (addr_i[1:0] == 2'b00);
        full_be  = (be_i == {BE_W{1'b1}});
        in_range = (int'(widx) < N_REG);
        ok_o     = aligned && full_be && in_range;
        sel_o    = '0;
        for (int k = 0; k < N_REG; k++) begin
            sel_o[k] = ok_o && (int'(widx) == k);
        end
    end

    // R7: at most one slot decoded for any address
    always_comb begin
        assert_sel_onehot_R7: assert ($onehot0(sel_o));
    end

endmodule

// File: rtl/pllb_slot.sv
module pllb_slot
    import pllb_pkg::*;
#(
    parameter logic [WORD_W-1:0] RST_VAL = '0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] word_o
);
    slot_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.word = merge_write(st_q.word, wdata_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.word <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o = st_q.word;

    assert_pdn_unlock_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i && wdata_i[PDN_BIT] |=> !word_o[LOCK_BIT] && word_o[LOSS_BIT]);

    assert_run_locked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i && !wdata_i[PDN_BIT] |=> word_o[LOCK_BIT]);

    assert_loss_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i && !wdata_i[PDN_BIT] && wdata_i[LOSS_BIT] |=> !word_o[LOSS_BIT]);

    assert_loss_keep_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i && !wdata_i[PDN_BIT] && !wdata_i[LOSS_BIT]
        |=> word_o[LOSS_BIT] == $past(word_o[LOSS_BIT]));

    assert_cfg_verbatim_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> (word_o & CFG_M) == ($past(wdata_i) & CFG_M));

    assert_idle_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_i |=> $stable(word_o));

endmodule

// File: rtl/pll_cfg_bank.sv
module pll_cfg_bank
    import pllb_pkg::*;
#(
    parameter int N_REG  = 4,
    parameter int ADDR_W = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BE_W-1:0]   be_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o
);
    logic                       acc_ok;
    logic [N_REG-1:0]           sel;
    logic [N_REG*WORD_W-1:0]    words_flat;
    logic [WORD_W-1:0]          rd_word;
    rd_state_t                  rd_d, rd_q;

    pllb_decode #(.N_REG(N_REG), .ADDR_W(ADDR_W)) u_dec (
        .addr_i (addr_i),
        .be_i   (be_i),
        .ok_o   (acc_ok),
        .sel_o  (sel)
    );

    for (genvar k = 0; k < N_REG; k++) begin : g_slot
        pllb_slot #(.RST_VAL(cold_word(k))) u_slot (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .wr_i    (wr_en_i && sel[k]),
            .wdata_i (wdata_i),
            .word_o  (words_flat[k*WORD_W +: WORD_W])
        );
    end

    always_comb begin
        rd_word = '0;
        for (int k = 0; k < N_REG; k++) begin
            if (sel[k]) begin
                rd_word = rd_word | words_flat[k*WORD_W +: WORD_W];
            end
        end
        rd_d = rd_q;
        if (rd_en_i) begin
            rd_d.rdata = acc_ok ? rd_word : '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rd_q.rdata <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata_o = rd_q.rdata;

    // R8: rejected write leaves every slot untouched
    assert_bad_wr_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i && !acc_ok |=> $stable(words_flat));

    // R8: rejected read returns zero
    assert_bad_rd_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_en_i && !acc_ok |=> rdata_o == '0);

    // R9: read data holds without a read strobe
    assert_rd_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> $stable(rdata_o));

endmodule

// File: tb/sim_pll_cfg_bank.sv
`timescale 1ns/1ps
module sim_pll_cfg_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [3:0]  be = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [31:0] mdl [4];

    always #2.5 clk = ~clk;

    pll_cfg_bank u0 (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .be_i(be), .wdata_i(wdata), .rdata_o(rdata)
    );

    function automatic logic [31:0] exp_store(logic [31:0] old, logic [31:0] w);
        logic [31:0] r;
        if (w[12]) begin
            r = w;
            r[31] = 1'b0;
            r[30] = 1'b1;
        end else begin
            r = w;
            r[31] = 1'b1;
            r[30] = w[30] ? 1'b0 : old[30];
        end
        return r;
    endfunction

    function automatic bit acc_valid(logic [5:0] a, logic [3:0] b);
        return (a[1:0] == 2'b00) && (b == 4'hF) && (a < 6'h10);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // inputs change at negedge; a write lands at the following posedge
    task automatic wr(logic [5:0] a, logic [3:0] b, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; be = b; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (acc_valid(a, b)) mdl[a[3:2]] = exp_store(mdl[a[3:2]], d);
    endtask

    task automatic rd(logic [5:0] a, logic [3:0] b, string req);
        logic [31:0] e;
        @(negedge clk);
        rd_en = 1'b1; addr = a; be = b;
        e = acc_valid(a, b) ? mdl[a[3:2]] : 32'h0;
        @(negedge clk);
        rd_en = 1'b0;
        check(req, rdata, e);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        mdl[0] = 32'h8022_2101; mdl[1] = 32'h8020_2101;
        mdl[2] = 32'h80C0_2105; mdl[3] = 32'h8122_8606;
        repeat (3) @(negedge clk);
        check("R9 reset rdata", rdata, 32'h0);
        rst_n = 1'b1;
        // R1 reset values
        for (int k = 0; k < 4; k++) rd(6'(k*4), 4'hF, "R1");

        // R2 power-down with lock written 1, loss 0
        wr(6'h00, 4'hF, 32'h8000_1ABC);
        rd(6'h00, 4'hF, "R2");
        check("R2 literal", rdata, 32'h4000_1ABC);
        // R5 powered write, loss 0 -> stays set
        wr(6'h00, 4'hF, 32'h0012_0345);
        rd(6'h00, 4'hF, "R5");
        check("R5 literal", rdata, 32'hC012_0345);
        // R4 clear by writing one
        wr(6'h00, 4'hF, 32'h4012_0345);
        rd(6'h00, 4'hF, "R4");
        check("R4 literal", rdata, 32'h8012_0345);
        // R3 and R6: all config bits ones, powered
        wr(6'h04, 4'hF, 32'h3FFF_EFFF);
        rd(6'h04, 4'hF, "R3 R6");
        check("R6 literal", rdata, 32'hBFFF_EFFF);
        // R7 neighbours untouched
        rd(6'h08, 4'hF, "R7 slot2");
        rd(6'h0C, 4'hF, "R7 slot3");
        // R8 rejected writes and reads
        wr(6'h09, 4'hF, 32'h0000_1000);
        wr(6'h08, 4'h7, 32'h0000_1000);
        wr(6'h10, 4'hF, 32'h0000_1000);
        rd(6'h08, 4'hF, "R8 write ignored");
        rd(6'h0A, 4'hF, "R8 misaligned read");
        rd(6'h0C, 4'h1, "R8 partial read");
        rd(6'h14, 4'hF, "R8 out of range");
        // R9 hold and read-during-write
        rd(6'h0C, 4'hF, "R9");
        @(negedge clk);
        check("R9 hold", rdata, mdl[3]);
        begin
            logic [31:0] old;
            old = mdl[3];
            @(negedge clk);
            wr_en = 1'b1; rd_en = 1'b1; addr = 6'h0C; be = 4'hF; wdata = 32'h0000_1111;
            @(negedge clk);
            wr_en = 1'b0; rd_en = 1'b0;
            mdl[3] = exp_store(mdl[3], 32'h0000_1111);
            check("R9 read before write", rdata, old);
        end
        rd(6'h0C, 4'hF, "R2 after rdw");

        // random phase
        for (int i = 0; i < 400; i++) begin
            logic [5:0]  a;
            logic [3:0]  b;
            logic [31:0] d;
            a = ($urandom_range(0, 9) == 0) ? 6'($urandom) : 6'($urandom_range(0, 3) * 4);
            b = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'hF;
            d = $urandom;
            d[12] = ($urandom_range(0, 2) == 0);
            d[30] = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 1) == 0) wr(a, b, d);
            else rd(a, b, "R2-R8 random");
        end
        for (int k = 0; k < 4; k++) rd(6'(k*4), 4'hF, "R7 final");
        summary();
    end

endmodule